// File: doc/BRIEF.md
# Dual-MAC Configuration Register Bank

This block holds the configuration words for two Ethernet MAC instances behind one host port. The host presents a 10-bit address, a MAC-select bit that acts as an eleventh address bit, and a management-select bit. The bank claims a transaction only when management-select is low and address bit 9 is set. When management-select is high, the transaction belongs to the MDIO side, and this bank neither writes nor answers.

Each MAC has seven 32-bit words. Writes land in a shadow copy, and reads always return the shadow copy. The receive words reach the receive datapath only on a clock edge where that MAC's receive inter-frame-gap input is high. The transmit and flow-control words move to the transmit datapath the same way, on the transmit gap input. The speed field moves only when both gap inputs are high together. Two reset bits skip this deferral and drive their reset outputs one cycle after the write. The management word also applies one cycle after the write, because it only sets the management clock, which is derived from the host clock.

The host port is a plain register port with no back-pressure. A write is accepted in the cycle it is strobed. A read always answers exactly one cycle later, with a valid pulse that carries the data.

Top module: `cfg_bank_dual`

## Requirements
- R1: Each MAC has its own seven words. They sit at offsets 0x200 (rx word A), 0x240 (rx word B), 0x280 (tx), 0x2C0 (flow control), 0x300 (mode), 0x320 (link status) and 0x340 (management), and `host_mac_sel` picks the MAC (0 or 1). A full 32-bit write to a writable word reads back whole, and the other MAC's word is left unchanged.
- R2: A transaction is claimed only when `host_mgmt_sel`=0 and `host_addr[9]`=1. An unclaimed write changes nothing, and an unclaimed read gives no `host_rvalid`.
- R3: A claimed read strobed at clock edge N gives `host_rvalid`=1 with `host_rdata` after edge N+1. This holds for one cycle. A claimed read of an offset outside the seven returns 0.
- R4: The live rx words (`rx_cfg0_live`, `rx_cfg1_live`) load the shadow values only on an edge where that MAC's `rx_ifg` bit is 1. Otherwise they hold.
- R5: The live tx and flow-control words load the shadow values only on an edge where that MAC's `tx_ifg` bit is 1. `rx_ifg` does not move them.
- R6: Bit 31 of rx word B drives `rx_reset`, and bit 31 of the tx word drives `tx_reset`. Each follows the written value one cycle after the write, whatever the gap inputs are.
- R7: Bits 31:30 of the mode word are the speed field, which can be written and read. Bits 29:0 always read as 0x0200_0000's low 30 bits. `speed_live` loads the field only on an edge where both `rx_ifg` and `tx_ifg` of that MAC are 1.
- R8: The link status word ignores writes and always reads 0x0000_0C00.
- R9: `mgmt_cfg` follows the management word one cycle after a write, without deferral.
- R10: After reset, both the shadow and live copies hold these values: rx A 0x0000_0000, rx B 0x1000_0000, tx 0x1000_0000, flow control 0x6000_0000, management 0x0000_0013, and speed 2'b00 (the lowest rate). Mode then reads 0x0200_0000, and both reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mac_sel | input | 1 | MAC instance select (address bit 10) |
| host_mgmt_sel | input | 1 | 1 routes the access to the MDIO space |
| host_addr | input | 10 | Host word address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid pulse |
| rx_ifg | input | 2 | Per-MAC receive inter-frame-gap indication |
| tx_ifg | input | 2 | Per-MAC transmit inter-frame-gap indication |
| rx_cfg0_live | output | 64 | Live rx word A, MAC m at [m*32+:32] |
| rx_cfg1_live | output | 64 | Live rx word B |
| tx_cfg_live | output | 64 | Live tx word |
| fc_cfg_live | output | 64 | Live flow-control word |
| speed_live | output | 4 | Live speed field, MAC m at [m*2+:2] |
| mgmt_cfg | output | 64 | Management word, applied immediately |
| rx_reset | output | 2 | Immediate receive reset per MAC |
| tx_reset | output | 2 | Immediate transmit reset per MAC |

## Verification
A read result is due at the first falling edge after the rising edge that samples the strobe. The driver pushes the expected word into a queue when it raises the strobe. The monitor pops that word on the next falling edge where `host_rvalid` is high, and the driver confirms that the pulse came at exactly that edge. Shadow writes, the reset outputs and `mgmt_cfg` are checked at the falling edge right after the write strobe. Live copies are checked twice: once after a write with the gaps held low, to show they have not moved, and again at the falling edge after a one-cycle gap pulse.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int NMAC  = 2;
  localparam int NREG  = 7;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int SPD_W = 2;

  typedef logic [DW-1:0] word_t;

  localparam int IX_RXA  = 0;
  localparam int IX_RXB  = 1;
  localparam int IX_TX   = 2;
  localparam int IX_FC   = 3;
  localparam int IX_MODE = 4;
  localparam int IX_LINK = 5;
  localparam int IX_MGMT = 6;

  localparam logic [AW-1:0] REG_OFS [NREG] =
    '{10'h200, 10'h240, 10'h280, 10'h2C0, 10'h300, 10'h320, 10'h340};

  localparam logic [NREG-1:0] FULL_RW = 7'b100_1111;

  localparam word_t RXA_DEF  = 32'h0000_0000;
  localparam word_t RXB_DEF  = 32'h1000_0000;
  localparam word_t TX_DEF   = 32'h1000_0000;
  localparam word_t FC_DEF   = 32'h6000_0000;
  localparam word_t MGMT_DEF = 32'h0000_0013;
  localparam logic [DW-SPD_W-1:0] MODE_FIXED = 30'h0200_0000;
  localparam word_t LINK_FIXED = 32'h0000_0C00;
  localparam int RST_BIT = 31;

  function automatic word_t reg_default(input int idx);
    case (idx)
      IX_RXA:  return RXA_DEF;
      IX_RXB:  return RXB_DEF;
      IX_TX:   return TX_DEF;
      IX_FC:   return FC_DEF;
      IX_MGMT: return MGMT_DEF;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mac_sel,
  input  logic            mgmt_sel,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic            rd,
  output logic [NREG-1:0] sel_o,
  output logic [NMAC-1:0] mac_we_o,
  output logic            rd_req_o
);
  logic claimed;
  assign claimed  = !mgmt_sel && addr[AW-1];
  assign rd_req_o = claimed && rd;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = claimed && (addr == REG_OFS[i]);
  end

  for (genvar m = 0; m < NMAC; m++) begin : g_we
    assign mac_we_o[m] = claimed && wr && (mac_sel == 1'(m));
  end

  p_onehot_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  p_mgmt_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_sel |-> (mac_we_o == '0) && !rd_req_o);
endmodule

// File: rtl/cfgb_mac_regs.sv
module cfgb_mac_regs
  import cfgb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NREG-1:0]    sel,
  input  word_t              wdata,
  input  logic               rx_gap,
  input  logic               tx_gap,
  output logic [NREG*DW-1:0] rd_words,
  output word_t              rxa_live,
  output word_t              rxb_live,
  output word_t              tx_live,
  output word_t              fc_live,
  output logic [SPD_W-1:0]   spd_live,
  output word_t              mgmt_cfg,
  output logic               rx_rst,
  output logic               tx_rst
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (FULL_RW[i]) begin : g_rw
      word_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)                q <= reg_default(i);
        else if (wr_en && sel[i])  q <= wdata;
      end
      assign rd_words[i*DW +: DW] = q;
    end else if (i == IX_MODE) begin : g_mode
      logic [SPD_W-1:0] spd;
      always_ff @(posedge clk) begin
        if (!rst_n)                spd <= '0;
        else if (wr_en && sel[i])  spd <= wdata[DW-1 -: SPD_W];
      end
      assign rd_words[i*DW +: DW] = {spd, MODE_FIXED};
    end else begin : g_ro
      assign rd_words[i*DW +: DW] = LINK_FIXED;
    end
  end

  word_t rxa_sh, rxb_sh, tx_sh, fc_sh;
  logic [SPD_W-1:0] spd_sh;
  assign rxa_sh = rd_words[IX_RXA*DW +: DW];
  assign rxb_sh = rd_words[IX_RXB*DW +: DW];
  assign tx_sh  = rd_words[IX_TX*DW +: DW];
  assign fc_sh  = rd_words[IX_FC*DW +: DW];
  assign spd_sh = rd_words[IX_MODE*DW + DW-1 -: SPD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxa_live <= RXA_DEF;
      rxb_live <= RXB_DEF;
      tx_live  <= TX_DEF;
      fc_live  <= FC_DEF;
      spd_live <= '0;
    end else begin
      if (rx_gap) begin
        rxa_live <= rxa_sh;
        rxb_live <= rxb_sh;
      end
      if (tx_gap) begin
        tx_live <= tx_sh;
        fc_live <= fc_sh;
      end
      if (rx_gap && tx_gap) spd_live <= spd_sh;
    end
  end

  assign mgmt_cfg = rd_words[IX_MGMT*DW +: DW];
  assign rx_rst   = rxb_sh[RST_BIT];
  assign tx_rst   = tx_sh[RST_BIT];

  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_gap |=> $stable(rxa_live) && $stable(rxb_live));
  p_rx_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gap |=> rxa_live == $past(rxa_sh));
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_gap |=> $stable(tx_live) && $stable(fc_live));
  p_rxrst_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[IX_RXB]) |=> rx_rst == $past(wdata[RST_BIT]));
  p_txrst_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[IX_TX]) |=> tx_rst == $past(wdata[RST_BIT]));
  p_spd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_gap && tx_gap) |=> $stable(spd_live));
endmodule

// File: rtl/cfgb_rdmux.sv
module cfgb_rdmux
  import cfgb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic                    mac_sel,
  input  logic [NREG-1:0]         sel,
  input  logic [NMAC*NREG*DW-1:0] words,
  output word_t                   rdata_o,
  output logic                    rvalid_o
);
  word_t pick;
  always_comb begin
    pick = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) pick = pick | words[(int'(mac_sel)*NREG + i)*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      rdata_o  <= rd_req ? pick : '0;
    end
  end

  p_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid_o);
  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid_o && rdata_o == '0);
endmodule

// File: rtl/cfg_bank_dual.sv
module cfg_bank_dual
  import cfgb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mac_sel,
  input  logic                 host_mgmt_sel,
  input  logic [AW-1:0]        host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  output logic                 host_rvalid,
  input  logic [NMAC-1:0]      rx_ifg,
  input  logic [NMAC-1:0]      tx_ifg,
  output logic [NMAC*DW-1:0]   rx_cfg0_live,
  output logic [NMAC*DW-1:0]   rx_cfg1_live,
  output logic [NMAC*DW-1:0]   tx_cfg_live,
  output logic [NMAC*DW-1:0]   fc_cfg_live,
  output logic [NMAC*SPD_W-1:0] speed_live,
  output logic [NMAC*DW-1:0]   mgmt_cfg,
  output logic [NMAC-1:0]      rx_reset,
  output logic [NMAC-1:0]      tx_reset
);
  logic [NREG-1:0]         sel;
  logic [NMAC-1:0]         mac_we;
  logic                    rd_req;
  logic [NMAC*NREG*DW-1:0] all_words;

  cfgb_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mac_sel(host_mac_sel), .mgmt_sel(host_mgmt_sel),
    .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .sel_o(sel), .mac_we_o(mac_we), .rd_req_o(rd_req)
  );

  for (genvar m = 0; m < NMAC; m++) begin : g_mac
    cfgb_mac_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(mac_we[m]), .sel(sel), .wdata(host_wdata),
      .rx_gap(rx_ifg[m]), .tx_gap(tx_ifg[m]),
      .rd_words(all_words[m*NREG*DW +: NREG*DW]),
      .rxa_live(rx_cfg0_live[m*DW +: DW]), .rxb_live(rx_cfg1_live[m*DW +: DW]),
      .tx_live(tx_cfg_live[m*DW +: DW]), .fc_live(fc_cfg_live[m*DW +: DW]),
      .spd_live(speed_live[m*SPD_W +: SPD_W]), .mgmt_cfg(mgmt_cfg[m*DW +: DW]),
      .rx_rst(rx_reset[m]), .tx_rst(tx_reset[m])
    );
  end

  cfgb_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mac_sel(host_mac_sel), .sel(sel),
    .words(all_words), .rdata_o(host_rdata), .rvalid_o(host_rvalid)
  );
endmodule

// File: tb/tb_cfg_bank_dual.sv
module tb_cfg_bank_dual;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_mac_sel = 0, host_mgmt_sel = 0, host_wr = 0, host_rd = 0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [1:0]  rx_ifg = 0, tx_ifg = 0;
  logic [63:0] rx_cfg0_live, rx_cfg1_live, tx_cfg_live, fc_cfg_live, mgmt_cfg;
  logic [3:0]  speed_live;
  logic [1:0]  rx_reset, tx_reset;

  always #4 clk = ~clk;

  cfg_bank_dual dut (.*);

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) chk("R3 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic mac, input logic mg, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    host_mac_sel = mac; host_mgmt_sel = mg; host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0; host_mgmt_sel = 0;
  endtask

  task automatic rd(input string tag, input logic mac, input logic mg, input logic [9:0] a,
                    input logic [31:0] e, input logic expect_v);
    @(negedge clk);
    host_mac_sel = mac; host_mgmt_sel = mg; host_addr = a; host_rd = 1;
    if (expect_v) begin exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk);
    host_rd = 0; host_mgmt_sel = 0;
    chk({tag, " latency"}, {31'd0, host_rvalid}, {31'd0, expect_v});
  endtask

  task automatic gap(input logic [1:0] r, input logic [1:0] t);
    @(negedge clk);
    rx_ifg = r; tx_ifg = t;
    @(negedge clk);
    rx_ifg = 0; tx_ifg = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rxa live", rx_cfg0_live[31:0], 32'h0000_0000);
    chk("R10 rxb live", rx_cfg1_live[63:32], 32'h1000_0000);
    chk("R10 tx live", tx_cfg_live[31:0], 32'h1000_0000);
    chk("R10 fc live", fc_cfg_live[63:32], 32'h6000_0000);
    chk("R10 mgmt", mgmt_cfg[31:0], 32'h0000_0013);
    chk("R10 resets", {28'd0, rx_reset, tx_reset}, 32'd0);
    chk("R10 speed", {28'd0, speed_live}, 32'd0);
    rd("R10 mode read", 0, 0, 10'h300, 32'h0200_0000, 1);
    rd("R10 fc read", 1, 0, 10'h2C0, 32'h6000_0000, 1);

    // R1 per-MAC words
    wr(0, 0, 10'h200, 32'hA5A5_0001);
    wr(1, 0, 10'h200, 32'h1234_5678);
    rd("R1 mac0 rxa", 0, 0, 10'h200, 32'hA5A5_0001, 1);
    rd("R1 mac1 rxa", 1, 0, 10'h200, 32'h1234_5678, 1);
    wr(1, 0, 10'h2C0, 32'hDEAD_BEEF);
    rd("R1 mac1 fc", 1, 0, 10'h2C0, 32'hDEAD_BEEF, 1);
    rd("R1 mac0 fc untouched", 0, 0, 10'h2C0, 32'h6000_0000, 1);

    // R4 rx deferral
    chk("R4 rxa held", rx_cfg0_live[31:0], 32'h0000_0000);
    gap(2'b01, 2'b00);
    chk("R4 rxa loaded", rx_cfg0_live[31:0], 32'hA5A5_0001);
    chk("R4 mac1 rxa held", rx_cfg0_live[63:32], 32'h0000_0000);

    // R5 tx deferral
    wr(0, 0, 10'h280, 32'h0000_00F0);
    chk("R5 tx held", tx_cfg_live[31:0], 32'h1000_0000);
    gap(2'b01, 2'b00);
    chk("R5 tx ignores rx gap", tx_cfg_live[31:0], 32'h1000_0000);
    gap(2'b00, 2'b01);
    chk("R5 tx loaded", tx_cfg_live[31:0], 32'h0000_00F0);

    // R6 immediate resets
    wr(0, 0, 10'h240, 32'h8000_0000);
    chk("R6 rx_reset now", {31'd0, rx_reset[0]}, 32'd1);
    chk("R6 rxb live deferred", rx_cfg1_live[31:0], 32'h1000_0000);
    wr(0, 0, 10'h280, 32'h8000_0000);
    chk("R6 tx_reset now", {31'd0, tx_reset[0]}, 32'd1);
    wr(0, 0, 10'h240, 32'h0000_0000);
    chk("R6 rx_reset clear", {31'd0, rx_reset[0]}, 32'd0);

    // R7 speed field
    wr(0, 0, 10'h300, 32'hFFFF_FFFF);
    rd("R7 mode read", 0, 0, 10'h300, 32'hC200_0000, 1);
    chk("R7 speed held", {28'd0, speed_live}, 32'd0);
    gap(2'b01, 2'b00);
    chk("R7 speed rx only", {28'd0, speed_live}, 32'd0);
    gap(2'b01, 2'b01);
    chk("R7 speed loaded", {28'd0, speed_live}, 32'd3);

    // R8 read-only link word
    wr(1, 0, 10'h320, 32'hFFFF_FFFF);
    rd("R8 link read", 1, 0, 10'h320, 32'h0000_0C00, 1);

    // R9 management immediate
    wr(1, 0, 10'h340, 32'h0000_0042);
    chk("R9 mgmt now", mgmt_cfg[63:32], 32'h0000_0042);

    // R3 unmapped read
    rd("R3 unmapped", 0, 0, 10'h204, 32'h0, 1);

    // R2 unclaimed
    wr(0, 1, 10'h200, 32'h5555_5555);
    rd("R2 mgmt write ignored", 0, 0, 10'h200, 32'hA5A5_0001, 1);
    rd("R2 mgmt read", 0, 1, 10'h200, 32'h0, 0);
    rd("R2 bit9 low read", 0, 0, 10'h000, 32'h0, 0);

    repeat (3) @(negedge clk);
    chk("R3 queue drained", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule